// File: doc/BRIEF.md
# Per-Port Asynchronous Serial Transceiver

This block adds an asynchronous serial mode to a single general-purpose port. When the receive enable is set, the port's second input pin (here `tr_in`) carries incoming frames. When the transmit enable is set, the port's third pin (here `tl_out`) carries outgoing frames. Two mode outputs tell the neighbouring parallel pin logic that these pins are taken over. A single configuration register selects one of four line rates and the two pin takeovers. It can also ask for a one-clock low pulse on the shared active-low attention line `hl_n` whenever a byte arrives. Reading the same register also returns three live status flags.

The transmit side and the receive side each hold one byte. A write to the transmit data address fills the transmit holding byte, and the transmitter drains it when it is idle. The receiver works from a 16x oversampling tick. It samples each bit near its centre, stores the byte and raises a ready flag. Reading the receive data address consumes the byte and clears both the ready flag and the error flag. The tick comes from a clock divider with a base divide `BASE_DIV`, which sets the fastest rate, scaled by 1, 2, 4 or 16 for the slower rates.

Top module: `ser_port_xcvr`

## Requirements
- R1: After synchronous reset the configuration/status read returns 0x00, `tl_out` is 1, both mode outputs are 0 and `hl_n` equals `hl_par_n`.
- R2: Register map on `addr`: 0 = configuration/status, 1 = transmit data (write), 2 = receive data (read). A configuration write keeps only bits 7..3. A configuration read returns those bits with receive error in bit 2, receive ready in bit 1 and transmit full in bit 0. `rdata` is valid in the cycle after `rd_en`.
- R3: Configuration bit 5 drives `rx_mode` and bit 4 drives `tx_mode`.
- R4: A transmitted frame is one low start bit, then eight data bits LSB first, then one high stop bit, and the line idles high. Each bit lasts 16*BASE_DIV*M clocks, where M is 1, 2, 4 or 16 for rate codes 00, 01, 10 and 11 in bits 7..6.
- R5: A write to transmit data sets transmit full. The flag clears only when the byte moves into the shifter, which happens only while `tx_mode` is 1. A second byte written during a frame is sent right after it, in order.
- R6: With `rx_mode` 1, a frame on `tr_in` at the selected rate sets receive ready, and a receive data read returns the byte. That read clears ready and error.
- R7: A stop bit that samples low sets receive error, and the byte is still stored.
- R8: With `rx_mode` 0, activity on `tr_in` sets no flag.
- R9: With bit 3 set, each received byte drives `hl_n` low for exactly one clock. With bit 3 clear, reception leaves `hl_n` alone.
- R10: `hl_n` is low whenever `hl_par_n` is low.
- R11: While `tx_mode` is 0 the transmitter is held idle, and `tl_out` is 1 from the cycle after the mode clears, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tr_in | input | 1 | Serial receive pin |
| tl_out | output | 1 | Serial transmit pin |
| rx_mode | output | 1 | Receive takeover flag for the parallel logic |
| tx_mode | output | 1 | Transmit takeover flag for the parallel logic |
| hl_par_n | input | 1 | Active-low attention from the parallel logic |
| hl_n | output | 1 | Combined active-low attention line |

## Verification
Read data is due in the cycle after the read strobe. The bench drives the strobe on a falling edge and samples `rdata` on the next falling edge. Configuration writes reach `tx_mode`/`rx_mode` one clock later, and `tl_out` returns high two clocks after the write strobe. The bench waits that long before it samples. A transmit frame starts within one tick of the byte being loaded. The bench's frame monitor therefore locks onto the falling start edge and samples each bit half a bit period after its nominal start, which stays inside the one-tick jitter. Receive flags are due by the middle of the stop bit, so status is read only after the whole stop bit has been driven. `hl_n` is compared against the parallel input on every clock, and the strobe pulse width and count are tracked there as well.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam logic [1:0] ADR_CFG = 2'd0;
  localparam logic [1:0] ADR_TXD = 2'd1;
  localparam logic [1:0] ADR_RXD = 2'd2;

  // scale factor applied to the base divide for each rate code
  function automatic int unsigned rate_mult(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 16;
    endcase
  endfunction

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI} rx_state_t;
endpackage

// File: rtl/ser_baud_gen.sv
module ser_baud_gen #(
  parameter int unsigned BASE_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int unsigned MAXLIM = BASE_DIV * 16;
  localparam int unsigned CW = $clog2(MAXLIM + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb lim = CW'(BASE_DIV * ser_pkg::rate_mult(rate) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= lim) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          pend,
  input  logic [DW-1:0] din,
  output logic          ack,
  output logic          line
);
  localparam int unsigned BW = $clog2(DW + 2);

  logic          busy_q;
  logic [DW:0]   sh_q;
  logic [3:0]    sub_q;
  logic [BW-1:0] bit_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy_q <= 1'b0;
      line   <= 1'b1;
      ack    <= 1'b0;
      sh_q   <= '1;
      sub_q  <= '0;
      bit_q  <= '0;
    end else begin
      ack <= 1'b0;
      if (!busy_q) begin
        if (pend) begin
          sh_q   <= {1'b1, din};
          line   <= 1'b0;
          busy_q <= 1'b1;
          ack    <= 1'b1;
          sub_q  <= '0;
          bit_q  <= '0;
        end
      end else if (tick) begin
        sub_q <= sub_q + 1'b1;
        if (sub_q == 4'd15) begin
          if (bit_q == BW'(DW + 1)) begin
            busy_q <= 1'b0;
            line   <= 1'b1;
          end else begin
            line  <= sh_q[0];
            sh_q  <= {1'b1, sh_q[DW:1]};
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ser_rx.sv
module ser_rx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          pin,
  output logic          done,
  output logic          ferr,
  output logic [DW-1:0] dout
);
  import ser_pkg::*;
  localparam int unsigned BW = $clog2(DW + 1);

  logic [1:0]    sync_q;
  logic          line;
  rx_state_t     st_q;
  logic [3:0]    sub_q;
  logic [BW-1:0] bit_q;

  assign line = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], pin};
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q  <= RX_IDLE;
      done  <= 1'b0;
      ferr  <= 1'b0;
      dout  <= '0;
      sub_q <= '0;
      bit_q <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        RX_IDLE: if (tick && !line) begin
          st_q  <= RX_START;
          sub_q <= '0;
        end
        RX_START: if (tick) begin
          if (sub_q == 4'd7) begin
            st_q  <= line ? RX_IDLE : RX_DATA;
            sub_q <= '0;
            bit_q <= '0;
          end else sub_q <= sub_q + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (sub_q == 4'd15) begin
            sub_q <= '0;
            dout  <= {line, dout[DW-1:1]};
            if (bit_q == BW'(DW - 1)) st_q <= RX_STOP;
            else                      bit_q <= bit_q + 1'b1;
          end else sub_q <= sub_q + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (sub_q == 4'd15) begin
            done <= 1'b1;
            ferr <= !line;
            st_q <= RX_WAITHI;
          end else sub_q <= sub_q + 1'b1;
        end
        default: if (line) st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ser_port_xcvr.sv
module ser_port_xcvr #(
  parameter int unsigned BASE_DIV = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          tr_in,
  output logic          tl_out,
  output logic          rx_mode,
  output logic          tx_mode,
  input  logic          hl_par_n,
  output logic          hl_n
);
  import ser_pkg::*;

  logic [4:0]    cfg_q;
  logic [DW-1:0] txbuf_q, rxbuf_q;
  logic          tx_full, rx_ready, rx_err, strobe_q;
  logic          tick, tx_ack, rx_done, rx_ferr;
  logic [DW-1:0] rx_byte;

  assign tx_mode = cfg_q[1];
  assign rx_mode = cfg_q[2];
  assign hl_n    = hl_par_n & ~strobe_q;

  ser_baud_gen #(.BASE_DIV(BASE_DIV)) i_baud (
    .clk(clk), .rst(rst), .rate(cfg_q[4:3]), .tick(tick)
  );

  ser_tx #(.DW(DW)) i_tx (
    .clk(clk), .rst(rst), .en(cfg_q[1]), .tick(tick), .pend(tx_full),
    .din(txbuf_q), .ack(tx_ack), .line(tl_out)
  );

  ser_rx #(.DW(DW)) i_rx (
    .clk(clk), .rst(rst), .en(cfg_q[2]), .tick(tick), .pin(tr_in),
    .done(rx_done), .ferr(rx_ferr), .dout(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      txbuf_q  <= '0;
      rxbuf_q  <= '0;
      tx_full  <= 1'b0;
      rx_ready <= 1'b0;
      rx_err   <= 1'b0;
      strobe_q <= 1'b0;
      rdata    <= '0;
    end else begin
      if (wr_en && addr == ADR_CFG) cfg_q <= wdata[7:3];

      if (wr_en && addr == ADR_TXD) begin
        txbuf_q <= wdata;
        tx_full <= 1'b1;
      end else if (tx_ack) tx_full <= 1'b0;

      strobe_q <= rx_done & cfg_q[0];
      if (rx_done) begin
        rxbuf_q  <= rx_byte;
        rx_ready <= 1'b1;
        rx_err   <= rx_ferr;
      end else if (rd_en && addr == ADR_RXD) begin
        rx_ready <= 1'b0;
        rx_err   <= 1'b0;
      end

      if (rd_en) begin
        case (addr)
          ADR_CFG: rdata <= {cfg_q, rx_err, rx_ready, tx_full};
          ADR_RXD: rdata <= rxbuf_q;
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ser_port_xcvr_chk.sv
module ser_port_xcvr_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic       tx_full,
  input logic       rx_ready,
  input logic [4:0] cfg_q,
  input logic       tx_mode,
  input logic       tl_out,
  input logic       hl_par_n,
  input logic       hl_n
);
  // R5
  tx_full_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_full) |-> $past(wr_en && addr == 2'd1));
  // R6
  rx_ready_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_ready) |-> $past(rd_en && addr == 2'd2));
  // R9
  hl_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_ready) && $past(cfg_q[0])) |-> !hl_n);
  // R9
  hl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (hl_par_n && !hl_n) |=> (hl_n || !hl_par_n));
  // R11
  tl_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_mode |=> tl_out);
endmodule

bind ser_port_xcvr ser_port_xcvr_chk i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .tx_full(tx_full), .rx_ready(rx_ready), .cfg_q(cfg_q), .tx_mode(tx_mode),
  .tl_out(tl_out), .hl_par_n(hl_par_n), .hl_n(hl_n)
);

// File: tb/test_ser_port_xcvr.sv
module test_ser_port_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_DIV = 4;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, tr_in = 1, hl_par_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic tl_out, rx_mode, tx_mode, hl_n;

  int vectors = 0, errors = 0, strobes = 0, bitc = 16 * BASE_DIV;
  bit mon_on = 0, prev_strobe = 0;
  logic [7:0] txq[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ser_port_xcvr #(.BASE_DIV(BASE_DIV)) i_ser_port_xcvr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tr_in(tr_in), .tl_out(tl_out),
    .rx_mode(rx_mode), .tx_mode(tx_mode), .hl_par_n(hl_par_n), .hl_n(hl_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic send(input logic [7:0] b, input logic stopb);
    logic [9:0] fr;
    fr = {stopb, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      tr_in = fr[i];
      repeat (bitc) @(negedge clk);
    end
    tr_in = 1;
    repeat (bitc) @(negedge clk);
  endtask

  // per-clock comparison of the attention line (R9, R10)
  always @(negedge clk) begin
    if (!rst) begin
      if (!hl_par_n && hl_n) chk(0, "R10", hl_n, 0);
      if (hl_par_n && !hl_n) begin
        strobes++;
        if (prev_strobe) chk(0, "R9 pulse width", 2, 1);
      end
      prev_strobe = hl_par_n && !hl_n;
    end
  end

  // transmit frame monitor against the queue of expected bytes (R4)
  initial begin
    logic [7:0] got;
    logic s0, s9;
    forever begin
      @(negedge clk);
      if (mon_on && !rst && !tl_out) begin
        repeat (bitc / 2) @(negedge clk);
        s0 = tl_out;
        for (int i = 0; i < 8; i++) begin
          repeat (bitc) @(negedge clk);
          got[i] = tl_out;
        end
        repeat (bitc) @(negedge clk);
        s9 = tl_out;
        chk(s0 == 0 && s9 == 1, "R4 framing", {s9, s0}, 2);
        if (txq.size() == 0) chk(0, "R4 unexpected frame", got, 0);
        else begin
          logic [7:0] e;
          e = txq.pop_front();
          chk(got == e, "R4 data", got, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rd(2'd0, d); chk(d == 8'h00, "R1 status", d, 0);
    chk(tl_out == 1, "R1 tl_out", tl_out, 1);
    chk(!rx_mode && !tx_mode, "R1 modes", {rx_mode, tx_mode}, 0);
    chk(hl_n == hl_par_n, "R1 hl_n", hl_n, hl_par_n);

    wr(2'd0, 8'hFF); rd(2'd0, d); chk(d == 8'hF8, "R2 write mask", d, 8'hF8);
    chk(rx_mode && tx_mode, "R3 modes on", {rx_mode, tx_mode}, 3);
    wr(2'd0, 8'h20); chk(rx_mode && !tx_mode, "R3 rx only", {rx_mode, tx_mode}, 2);
    wr(2'd0, 8'h00);

    // R5/R11: byte waits while the transmitter is disabled
    wr(2'd1, 8'h5A); rd(2'd0, d); chk(d == 8'h01, "R5 full held", d, 1);
    repeat (200) begin @(negedge clk); if (!tl_out) chk(0, "R11 line idle", 0, 1); end
    mon_on = 1; txq.push_back(8'h5A);
    wr(2'd0, 8'h10);
    repeat (12 * bitc) @(negedge clk);
    chk(txq.size() == 0, "R5 sent", txq.size(), 0);
    rd(2'd0, d); chk(d == 8'h10, "R5 full cleared", d, 8'h10);

    // R5: two bytes back to back
    txq.push_back(8'hA5); txq.push_back(8'h3C);
    wr(2'd1, 8'hA5); wr(2'd1, 8'h3C);
    rd(2'd0, d); chk(d[0] == 1, "R5 second pending", d[0], 1);
    repeat (23 * bitc) @(negedge clk);
    chk(txq.size() == 0, "R5 order", txq.size(), 0);

    // R4: other rate codes
    for (int r = 1; r < 4; r++) begin
      logic [7:0] b;
      b = 8'hC3 ^ 8'(r * 17);
      bitc = 16 * BASE_DIV * ((r == 3) ? 16 : (1 << r));
      wr(2'd0, {2'(r), 6'h10});
      txq.push_back(b); wr(2'd1, b);
      repeat (12 * bitc) @(negedge clk);
      chk(txq.size() == 0, "R4 rate", r, txq.size());
    end
    bitc = 16 * BASE_DIV;

    // R6: receive without strobe
    wr(2'd0, 8'h20); strobes = 0;
    send(8'h96, 1);
    rd(2'd0, d); chk(d == 8'h22, "R6 ready", d, 8'h22);
    rd(2'd2, d); chk(d == 8'h96, "R6 data", d, 8'h96);
    rd(2'd0, d); chk(d == 8'h20, "R6 cleared", d, 8'h20);
    chk(strobes == 0, "R9 no strobe", strobes, 0);

    // R9: strobe enabled
    wr(2'd0, 8'h28);
    send(8'h71, 1);
    chk(strobes == 1, "R9 strobe", strobes, 1);
    rd(2'd2, d); chk(d == 8'h71, "R6 data2", d, 8'h71);

    // R7: framing error
    send(8'hE4, 0);
    rd(2'd0, d); chk(d == 8'h2E, "R7 error", d, 8'h2E);
    rd(2'd2, d); chk(d == 8'hE4, "R7 data kept", d, 8'hE4);
    rd(2'd0, d); chk(d == 8'h28, "R7 cleared", d, 8'h28);

    // R8: receiver disabled
    wr(2'd0, 8'h08); strobes = 0;
    send(8'h55, 1);
    rd(2'd0, d); chk(d == 8'h08, "R8 ignored", d, 8'h08);
    chk(strobes == 0, "R8 no strobe", strobes, 0);

    // R10: parallel source low
    @(negedge clk); hl_par_n = 0;
    @(negedge clk); chk(hl_n == 0, "R10", hl_n, 0);
    hl_par_n = 1;

    // R11: abort mid-frame
    mon_on = 0;
    wr(2'd0, 8'h10); wr(2'd1, 8'h00);
    repeat (3 * bitc) @(negedge clk);
    chk(tl_out == 0, "R11 frame running", tl_out, 0);
    wr(2'd0, 8'h00); @(negedge clk);
    chk(tl_out == 1, "R11 abort", tl_out, 1);
    repeat (2 * bitc) begin @(negedge clk); if (!tl_out) chk(0, "R11 stays idle", 0, 1); end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule